// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. The virtual address carries three fields. Bits 31:22 index the top-level table. Bits 21:12 index a second-level table. Bits 11:0 are the byte offset inside a 4 KB page. Each table has 1024 entries of four bytes. The top-level table starts at a base register, so switching address space means rewriting only that one register.

A walk starts when a request is accepted. The walker then reads one word from the top-level table, and that entry names a second-level table. It reads one word from that second-level table, and that entry names the physical page. It returns the physical address, or a page fault that carries the virtual address that failed. Only one walk runs at a time. The memory port is a simple request/response pair: the request stays up until the response arrives. The table base can be rewritten only in kernel mode. A rewrite attempted in user mode is dropped and raises a flag.

Top module: `pgw_top`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid`, `resp_valid` and `priv_viol` are 0, and the table base is 0.
- R2: In the cycle after a request is accepted, `mem_req_valid` is 1 and `mem_req_addr` equals the table base plus four times virtual address bits 31:22.
- R3: In the cycle after a valid top-level entry is returned, `mem_req_addr` equals that entry's bits 31:12 followed by twelve zero bits, plus four times virtual address bits 21:12.
- R4: When the second-level entry is valid, the walker returns `resp_fault` = 0 and `resp_paddr` = {entry bits 31:12, virtual address bits 11:0}.
- R5: An entry is valid when its bit 0 is 1. A top-level entry with bit 0 clear ends the walk with no second read. The response has `resp_fault` = 1, `resp_paddr` = 0 and `resp_vaddr` = the requested virtual address.
- R6: A second-level entry with bit 0 clear ends the walk with `resp_fault` = 1, `resp_paddr` = 0 and `resp_vaddr` = the requested virtual address.
- R7: `req_ready` is 0 from acceptance through the response cycle. A request offered during a walk is ignored, and the walk in progress keeps its own virtual address.
- R8: A base write with `kernel_mode` = 1 takes effect at the next clock edge and is used by later walks.
- R9: A base write with `kernel_mode` = 0 leaves the base unchanged. It sets `priv_viol` to 1 for exactly the following cycle.
- R10: `resp_valid` is 1 for exactly one cycle, the cycle after the final memory response. `req_ready` returns to 1 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kernel_mode | input | 1 | 1 when the current privilege is kernel |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 32 | New table base value |
| priv_viol | output | 1 | One-cycle pulse after a base write is attempted in user mode |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_req_valid | output | 1 | Table read request, held until answered |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry word read from memory |
| resp_valid | output | 1 | Translation result strobe |
| resp_fault | output | 1 | 1 when the walk ended on an invalid entry |
| resp_paddr | output | 32 | Physical address, or 0 on a fault |
| resp_vaddr | output | 32 | Virtual address of the walk that finished |

## Verification
The bench checks that the top-level index scales by four and is added to the base. A walker that does not scale it would read the wrong entry, and a walker that concatenated instead of adding would break when the base is not aligned to the table size. It also uses an all-ones virtual address, so an index or offset that spills into the frame bits shows up in the physical address. For a fault at the first level, the bench confirms that no second read follows; a walker that carried on would issue a spurious memory request. It also checks that a request offered mid-walk does not replace the captured address, and that a user-mode base write neither changes the address of the next walk nor fails to pulse the flag.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;
    localparam int ENT_SH  = 2;
    localparam int FRAME_W = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LVL1 = 2'd1,
        WS_LVL2 = 2'd2,
        WS_DONE = 2'd3
    } walk_st_e;

    typedef struct packed {
        logic [IDX_W-1:0] dir_idx;
        logic [IDX_W-1:0] tbl_idx;
        logic [OFF_W-1:0] offset;
    } vaddr_t;

    typedef struct packed {
        logic [FRAME_W-1:0]     frame;
        logic [OFF_W-2:0]       spare;
        logic                   present;
    } pte_t;

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [ADDR_W-1:0] base,
        input logic [IDX_W-1:0]  idx
    );
        logic [ADDR_W-1:0] scaled;
        scaled = ADDR_W'(idx) << ENT_SH;
        return base + scaled;
    endfunction

    function automatic logic [ADDR_W-1:0] frame_base(input pte_t e);
        return {e.frame, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/pgw_base_reg.sv
module pgw_base_reg
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kernel_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q,
    output logic              viol_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            viol_q <= 1'b0;
        end else begin
            if (wr_en && kernel_mode)
                base_q <= wr_data;
            viol_q <= wr_en && !kernel_mode;
        end
    end
endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              req_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [ADDR_W-1:0] resp_vaddr,
    output walk_st_e          state
);
    walk_st_e          st_q;
    vaddr_t            va_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] pa_q;
    logic              fault_q;
    pte_t              rsp_pte;

    assign rsp_pte = pte_t'(mem_rsp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= WS_IDLE;
            va_q    <= '0;
            addr_q  <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            case (st_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q    <= vaddr_t'(req_vaddr);
                        addr_q  <= entry_addr(base, req_vaddr[ADDR_W-1 -: IDX_W]);
                        fault_q <= 1'b0;
                        pa_q    <= '0;
                        st_q    <= WS_LVL1;
                    end
                end
                WS_LVL1: begin
                    if (mem_rsp_valid) begin
                        if (rsp_pte.present) begin
                            addr_q <= entry_addr(frame_base(rsp_pte), va_q.tbl_idx);
                            st_q   <= WS_LVL2;
                        end else begin
                            fault_q <= 1'b1;
                            pa_q    <= '0;
                            st_q    <= WS_DONE;
                        end
                    end
                end
                WS_LVL2: begin
                    if (mem_rsp_valid) begin
                        if (rsp_pte.present) begin
                            pa_q    <= {rsp_pte.frame, va_q.offset};
                            fault_q <= 1'b0;
                        end else begin
                            pa_q    <= '0;
                            fault_q <= 1'b1;
                        end
                        st_q <= WS_DONE;
                    end
                end
                default: st_q <= WS_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (st_q == WS_IDLE);
        mem_req_valid = (st_q == WS_LVL1) || (st_q == WS_LVL2);
        mem_req_addr  = addr_q;
        resp_valid    = (st_q == WS_DONE);
        resp_fault    = fault_q;
        resp_paddr    = pa_q;
        resp_vaddr    = ADDR_W'(va_q);
        state         = st_q;
    end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        kernel_mode,
    input  logic        base_wr_en,
    input  logic [31:0] base_wr_data,
    output logic        priv_viol,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    output logic        req_ready,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        resp_valid,
    output logic        resp_fault,
    output logic [31:0] resp_paddr,
    output logic [31:0] resp_vaddr
);
    logic [ADDR_W-1:0] base_q;
    walk_st_e          walk_state;

    pgw_base_reg u_base (
        .clk         (clk),
        .rst         (rst),
        .kernel_mode (kernel_mode),
        .wr_en       (base_wr_en),
        .wr_data     (base_wr_data),
        .base_q      (base_q),
        .viol_q      (priv_viol)
    );

    pgw_walk_fsm u_walk (
        .clk           (clk),
        .rst           (rst),
        .base          (base_q),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_paddr    (resp_paddr),
        .resp_vaddr    (resp_vaddr),
        .state         (walk_state)
    );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
    import pgw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              kernel_mode,
    input logic              base_wr_en,
    input logic              priv_viol,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [ADDR_W-1:0] mem_rsp_data,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [ADDR_W-1:0] resp_paddr,
    input logic [ADDR_W-1:0] base_q,
    input walk_st_e          walk_state
);
    AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_req_valid &&
            mem_req_addr == $past(base_q) + {20'd0, $past(req_vaddr[31:22]), 2'b00})); // R2
    AST_SUCCESS_PADDR: assert property (@(posedge clk) disable iff (rst)
        (walk_state == WS_LVL2 && mem_rsp_valid && mem_rsp_data[0]) |=>
            (resp_valid && !resp_fault && resp_paddr[31:12] == $past(mem_rsp_data[31:12]))); // R4
    AST_L1_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (walk_state == WS_LVL1 && mem_rsp_valid && !mem_rsp_data[0]) |=>
            (resp_valid && resp_fault && !mem_req_valid)); // R5
    AST_NOT_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready); // R7
    AST_USER_WR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (base_wr_en && !kernel_mode) |=> (priv_viol && $stable(base_q))); // R9
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready)); // R10
endmodule

bind pgw_top pgw_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .kernel_mode   (kernel_mode),
    .base_wr_en    (base_wr_en),
    .priv_viol     (priv_viol),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .resp_valid    (resp_valid),
    .resp_fault    (resp_fault),
    .resp_paddr    (resp_paddr),
    .base_q        (base_q),
    .walk_state    (walk_state)
);

// File: tb/pgw_top_tb_top.sv
module pgw_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        kernel_mode = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        priv_viol;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        resp_valid;
    logic        resp_fault;
    logic [31:0] resp_paddr;
    logic [31:0] resp_vaddr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pgw_top dut_i (
        .clk(clk), .rst(rst), .kernel_mode(kernel_mode),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .priv_viol(priv_viol),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .resp_vaddr(resp_vaddr)
    );

    // {base, vaddr, first-level entry, second-level entry}
    localparam logic [127:0] VECS [6] = '{
        {32'h0010_0000, 32'h0040_3ABC, 32'h0020_0001, 32'h0ABC_D001},
        {32'h0010_0000, 32'hFFFF_FFFF, 32'h1234_5FFF, 32'h8765_4003},
        {32'h0010_0000, 32'h0000_0000, 32'h0030_0000, 32'h0000_0001},
        {32'h0010_0000, 32'h8020_1010, 32'h0050_0001, 32'h0060_0FFE},
        {32'h0000_4004, 32'h0123_4567, 32'hABCD_E3F1, 32'h1357_9001},
        {32'h7FFF_F000, 32'hFFC0_0000, 32'h0000_1001, 32'hFFFF_F001}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] v, input bit kern);
        @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = v;
        kernel_mode  = kern;
        @(negedge clk);
        base_wr_en   = 1'b0;
        kernel_mode  = 1'b0;
    endtask

    task automatic walk(input logic [31:0] base, input logic [31:0] va,
                        input logic [31:0] e1, input logic [31:0] e2, input bit poke);
        logic [31:0] a1, a2, pa;
        bit f;
        a1 = base + (32'(va >> 22) << 2);
        a2 = {e1[31:12], 12'h000} + (32'((va >> 12) & 32'h3FF) << 2);
        f  = !e1[0] || !e2[0];
        pa = f ? 32'h0 : {e2[31:12], va[11:0]};
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = poke;
        req_vaddr = ~va;
        check(mem_req_valid && mem_req_addr == a1, "R2 first read address", mem_req_addr, a1);
        check(!req_ready, "R7 ready low while walking", 32'(req_ready), 32'h0);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = e1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        req_valid     = 1'b0;
        if (e1[0]) begin
            check(mem_req_valid && mem_req_addr == a2, "R3 second read address", mem_req_addr, a2);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = e2;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end else begin
            check(!mem_req_valid, "R5 no second read after top-level fault", 32'(mem_req_valid), 32'h0);
        end
        check(resp_valid, "R10 response strobe", 32'(resp_valid), 32'h1);
        check(resp_fault == f, f ? (e1[0] ? "R6 fault flag" : "R5 fault flag") : "R4 fault flag",
              32'(resp_fault), 32'(f));
        check(resp_paddr == pa, f ? "R6 paddr on fault" : "R4 physical address", resp_paddr, pa);
        check(resp_vaddr == va, poke ? "R7 vaddr kept despite busy request" : "R5 reported vaddr",
              resp_vaddr, va);
        @(negedge clk);
        check(!resp_valid && req_ready, "R10 single-cycle response", 32'(resp_valid), 32'h0);
        check(!mem_req_valid, "R7 busy request not started", 32'(mem_req_valid), 32'h0);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(req_ready && !mem_req_valid && !resp_valid && !priv_viol,
              "R1 reset outputs", {28'd0, req_ready, mem_req_valid, resp_valid, priv_viol}, 32'h8);
        walk(32'h0, 32'h0080_5123, 32'h0040_0001, 32'h0090_0001, 1'b0); // R1 base 0

        for (int i = 0; i < 6; i++) begin
            set_base(VECS[i][127:96], 1'b1); // R8 kernel write
            check(!priv_viol, "R8 no flag on kernel write", 32'(priv_viol), 32'h0);
            walk(VECS[i][127:96], VECS[i][95:64], VECS[i][63:32], VECS[i][31:0], i == 0);
        end

        // R9 user-mode write ignored, flag pulses once
        @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = 32'h5555_0000;
        kernel_mode  = 1'b0;
        @(negedge clk);
        base_wr_en = 1'b0;
        check(priv_viol, "R9 flag after user write", 32'(priv_viol), 32'h1);
        @(negedge clk);
        check(!priv_viol, "R9 flag lasts one cycle", 32'(priv_viol), 32'h0);
        walk(VECS[5][127:96], 32'h0040_0000, 32'h0000_2001, 32'h0003_3001, 1'b0); // R9 base unchanged

        // R8 back-to-back kernel writes: last wins
        set_base(32'h0000_8000, 1'b1);
        set_base(32'h0001_0000, 1'b1);
        walk(32'h0001_0000, 32'h0C00_0FFF, 32'h0000_0000, 32'h0, 1'b1); // R8, R5 with busy poke

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule